// File: doc/BRIEF.md
# Serial Register Port with Line Status Interrupt

This block is the control-side slave of a four-line transceiver. A host reaches it over a three-wire serial port with chip select, serial clock and serial data in, plus a serial data out. The host may clock this port independently of the block's own clock. Each access is one 16-clock frame. The frame carries an address byte and then a data byte. While the data byte is shifted in, the block shifts out a response byte. Through this port the host programs six slot-assignment bytes and one control byte for each line, and reads a shared status byte.

The block also tracks a two-bit condition code for each line. The code comes from line-signal and in-sync inputs that are synchronised into the block clock. Bipolar violations arrive as toggle events and are recorded until the host reads the status byte. A latched, active-low interrupt tells the host that some line with interrupts enabled has changed condition.

All serial inputs and line inputs are brought into the `clk` domain through two-flop synchronisers. Every edge is then detected in that domain. The serial clock therefore has to be several times slower than `clk`.

Top module: `mw_regport`

## Requirements
- R1: A frame is 16 rising serial-clock edges with `cs_n` low. The first byte is the address and the second is the data, each sent MSB first. The response byte is output during the data byte, MSB first. It is 0 during the address byte.
- R2: `co` changes only on falling serial-clock edges. `co_oe` is 0 while `cs_n` is high and 1 while a frame is open.
- R3: Address bits 7..4 pick the line (0 to 3). Address bits 3..1 pick the register: 0 = transmit D slot, 1 = transmit B1, 2 = transmit B2, 3 = receive D, 4 = receive B1, 5 = receive B2, 7 = control. Line n, register k appears on `slot_o[(n*6+k)*8 +: 8]`. The control byte of line n appears on `ctrl_o[n*8 +: 8]`.
- R4: If address bit 0 is 0, the data byte is written and the old contents are returned. If address bit 0 is 1, the register is only read back and is left unchanged.
- R5: Address 0xFF returns the status byte. Line n uses bits 2n+1..2n. The codes are: 00 = no signal, 01 = signal present but not in sync, 11 = in sync with no violation, 10 = in sync with a violation recorded.
- R6: A violation toggle on a line that is in sync sets code 10. The code stays at 10 until a status read, which returns it to 11. Losing sync also drops the violation record.
- R7: A violation never drives `int_n` low.
- R8: `int_n` goes low when a line's base code (00/01/11) changes and bit 2 of that line's control byte is 1. A change on a line whose bit 2 is 0 has no effect on `int_n`. `int_n` returns high once the address byte of a status read has been received.
- R9: After reset, all register bytes are 0, `int_n` is 1 and `co_oe` is 0. Control bit 7 means activate, bit 6 digital loopback, bit 5 full line loopback, bit 4 B1 loopback and bit 3 B2 loopback. All of these bits go straight out on `ctrl_o`.
- R10: If `cs_n` rises before the 16th rising edge, nothing is written.
- R11: The following addresses return 0 and writing them changes nothing: register select 6, line nibble 4 or above (other than 0xFF), and 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial port select, active low |
| cclk | input | 1 | Serial clock |
| ci | input | 1 | Serial data in |
| ln_sig | input | LINES | Line signal present, per line (level) |
| ln_sync | input | LINES | Line in sync, per line (level) |
| ln_bpv_tgl | input | LINES | Violation event, one toggle per event |
| co | output | 1 | Serial data out |
| co_oe | output | 1 | Drive enable for `co` |
| int_n | output | 1 | Latched interrupt, active low |
| ctrl_o | output | LINES*8 | Control bytes of all lines |
| slot_o | output | LINES*6*8 | Slot-assignment bytes of all lines |

## Verification
The bench checks that a write returns the previous contents and that a read-back leaves the byte unchanged. A design that swapped the roles of even and odd addresses would corrupt registers on a read. It then cuts a frame after 12 clocks: a design that committed on a bit count would latch half a byte. It produces a violation with interrupts enabled and expects `int_n` to stay high. It expects the code 10 to turn into 11 on the second status read, which catches a design that clears the record early or never clears it. Finally it changes condition on a line whose interrupt bit is 0, which exposes an interrupt mask that is missing or applied to the wrong line.

// File: rtl/mw_regport.sv
module mw_regport #(
  parameter int LINES = 4,
  parameter int SLOTS = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     cclk,
  input  logic                     ci,
  input  logic [LINES-1:0]         ln_sig,
  input  logic [LINES-1:0]         ln_sync,
  input  logic [LINES-1:0]         ln_bpv_tgl,
  output logic                     co,
  output logic                     co_oe,
  output logic                     int_n,
  output logic [LINES*8-1:0]       ctrl_o,
  output logic [LINES*SLOTS*8-1:0] slot_o
);
  localparam int  CNTW     = 5;
  localparam int  FRAME    = 16;
  localparam logic [2:0] CTRL_SEL = 3'd7;
  localparam logic [7:0] ST_ADDR  = 8'hFF;

  logic [2:0] cclk_p, cs_p;
  logic [1:0] ci_p;
  logic [LINES-1:0] sig_a, sig_b, syn_a, syn_b, bpv_a, bpv_b, bpv_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cclk_p <= '0; cs_p <= '1; ci_p <= '0;
      sig_a <= '0; sig_b <= '0; syn_a <= '0; syn_b <= '0;
      bpv_a <= '0; bpv_b <= '0; bpv_c <= '0;
    end else begin
      cclk_p <= {cclk_p[1:0], cclk};
      cs_p   <= {cs_p[1:0], cs_n};
      ci_p   <= {ci_p[0], ci};
      sig_a <= ln_sig;     sig_b <= sig_a;
      syn_a <= ln_sync;    syn_b <= syn_a;
      bpv_a <= ln_bpv_tgl; bpv_b <= bpv_a; bpv_c <= bpv_b;
    end

  wire active = ~cs_p[1];
  wire rise   = cclk_p[1] & ~cclk_p[2];
  wire fall   = ~cclk_p[1] & cclk_p[2];
  wire ci_s   = ci_p[1];

  logic [CNTW-1:0] cnt;
  logic [7:0] sh_in, addr_q, out_sh, rd_byte, status;
  logic co_q;
  logic [7:0] ctrl_q [LINES];
  logic [7:0] slot_q [LINES][SLOTS];

  wire [7:0] addr_nxt = {sh_in[6:0], ci_s};
  wire ld     = active & rise & (cnt == CNTW'(7));
  wire st_cap = ld & (addr_nxt == ST_ADDR);
  wire last   = active & rise & (cnt == CNTW'(FRAME-1));

  function automatic logic reg_ok(input logic [7:0] a);
    logic hit;
    hit = 1'b0;
    for (int l = 0; l < LINES; l++)
      if (a[7:4] == 4'(l) && (a[3:1] == CTRL_SEL || 32'(a[3:1]) < SLOTS)) hit = 1'b1;
    return hit;
  endfunction

  wire wr_en = last & ~addr_q[0] & reg_ok(addr_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sh_in <= '0; addr_q <= '0; out_sh <= '0; co_q <= 1'b0;
    end else if (!active) begin
      cnt <= '0; out_sh <= '0; co_q <= 1'b0;
    end else begin
      if (rise && cnt != CNTW'(FRAME)) begin
        sh_in <= addr_nxt;
        cnt   <= cnt + 1'b1;
      end
      if (ld) begin
        addr_q <= addr_nxt;
        out_sh <= rd_byte;
      end else if (fall) begin
        co_q   <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
    end

  always_comb begin
    rd_byte = '0;
    if (addr_nxt == ST_ADDR) rd_byte = status;
    else if (reg_ok(addr_nxt))
      for (int l = 0; l < LINES; l++)
        if (addr_nxt[7:4] == 4'(l)) begin
          if (addr_nxt[3:1] == CTRL_SEL) rd_byte = ctrl_q[l];
          else
            for (int k = 0; k < SLOTS; k++)
              if (addr_nxt[3:1] == 3'(k)) rd_byte = slot_q[l][k];
        end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        ctrl_q[l] <= '0;
        for (int k = 0; k < SLOTS; k++) slot_q[l][k] <= '0;
      end
    end else if (wr_en) begin
      for (int l = 0; l < LINES; l++)
        if (addr_q[7:4] == 4'(l)) begin
          if (addr_q[3:1] == CTRL_SEL) ctrl_q[l] <= addr_nxt;
          for (int k = 0; k < SLOTS; k++)
            if (addr_q[3:1] == 3'(k)) slot_q[l][k] <= addr_nxt;
        end
    end

  logic [1:0] base [LINES];
  logic [1:0] prev_q [LINES];
  logic [LINES-1:0] vflag, chg_l;
  logic int_q;
  wire chg = |chg_l;

  always_comb begin
    status = '0;
    for (int l = 0; l < LINES; l++) begin
      base[l]  = syn_b[l] ? 2'b11 : (sig_b[l] ? 2'b01 : 2'b00);
      chg_l[l] = (base[l] != prev_q[l]) & ctrl_q[l][2];
      if (l < 4) status[2*l +: 2] = vflag[l] ? 2'b10 : base[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vflag <= '0; int_q <= 1'b0;
      for (int l = 0; l < LINES; l++) prev_q[l] <= '0;
    end else begin
      for (int l = 0; l < LINES; l++) begin
        prev_q[l] <= base[l];
        if (!syn_b[l])                  vflag[l] <= 1'b0;
        else if (bpv_b[l] ^ bpv_c[l])  vflag[l] <= 1'b1;
        else if (st_cap)               vflag[l] <= 1'b0;
      end
      if (chg)         int_q <= 1'b1;
      else if (st_cap) int_q <= 1'b0;
    end

  for (genvar l = 0; l < LINES; l++) begin : g_out
    assign ctrl_o[l*8 +: 8] = ctrl_q[l];
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign slot_o[(l*SLOTS+k)*8 +: 8] = slot_q[l][k];
    end
  end

  assign co    = co_q;
  assign co_oe = active;
  assign int_n = ~int_q;
endmodule

module mw_regport_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             co_oe,
  input logic             int_n,
  input logic [LINES*8-1:0] ctrl_o,
  input logic             wr_en,
  input logic [7:0]       addr_q,
  input logic             st_cap,
  input logic             chg
);
  p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !co_oe);
  p_odd_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !addr_q[0]);
  p_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_o));
  p_bpv_noint_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_n && !chg |=> int_n);
  p_int_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_cap && !chg |=> int_n);
endmodule

bind mw_regport mw_regport_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .co_oe(co_oe), .int_n(int_n),
  .ctrl_o(ctrl_o), .wr_en(wr_en), .addr_q(addr_q), .st_cap(st_cap), .chg(chg)
);

// File: tb/mw_regport_tb_top.sv
module mw_regport_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, cclk = 1'b0, ci = 1'b0;
  logic [3:0] ln_sig = '0, ln_sync = '0, ln_bpv_tgl = '0;
  logic co, co_oe, int_n;
  logic [31:0] ctrl_o;
  logic [191:0] slot_o;
  int checks = 0, failures = 0;
  logic [7:0] r;

  always #5 clk = ~clk;

  mw_regport dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cclk(cclk), .ci(ci),
    .ln_sig(ln_sig), .ln_sync(ln_sync), .ln_bpv_tgl(ln_bpv_tgl),
    .co(co), .co_oe(co_oe), .int_n(int_n), .ctrl_o(ctrl_o), .slot_o(slot_o));

  // {address, data, expected response}
  localparam logic [23:0] VEC [12] = '{
    {8'h02, 8'h85, 8'h00},  // R4 write TX B1 line0, old = 0
    {8'h03, 8'h00, 8'h85},  // R4 read back
    {8'h02, 8'h11, 8'h85},  // R4 write returns previous
    {8'h03, 8'hFF, 8'h11},  // R4 odd leaves it
    {8'h3E, 8'hA4, 8'h00},  // R3 line3 control
    {8'h3F, 8'h00, 8'hA4},  // R3
    {8'h1A, 8'h7F, 8'h00},  // R3 line1 RX B2
    {8'h1B, 8'h00, 8'h7F},  // R1 MSB-first data path
    {8'h0C, 8'h55, 8'h00},  // R11 select 6 ignored
    {8'h0D, 8'h00, 8'h00},  // R11
    {8'h40, 8'hAA, 8'h00},  // R11 line nibble 4
    {8'h41, 8'h00, 8'h00}   // R11
  };

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nb,
                      output logic [7:0] resp);
    resp = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      ci = (i < 8) ? a[7-i] : d[15-i];
      repeat (8) @(negedge clk);
      if (i >= 8) resp[15-i] = co;
      cclk = 1'b1;
      repeat (8) @(negedge clk);
      cclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 int_n reset", 192'(int_n), 192'(1));
    chk("R9 co_oe reset", 192'(co_oe), 192'(0));
    chk("R9 ctrl reset", 192'(ctrl_o), 192'(0));
    chk("R9 slot reset", slot_o, 192'(0));

    for (int v = 0; v < 12; v++) begin
      xfer(VEC[v][23:16], VEC[v][15:8], 16, r);
      chk($sformatf("R4/R3/R11 vec %0d", v), 192'(r), 192'(VEC[v][7:0]));
    end
    chk("R3 slot line0 k1", 192'(slot_o[15:8]), 192'(8'h11));
    chk("R3 slot line1 k5", 192'(slot_o[(1*6+5)*8 +: 8]), 192'(8'h7F));
    chk("R9 ctrl line3", 192'(ctrl_o[31:24]), 192'(8'hA4));

    // R2 co_oe while frame open
    @(negedge clk); cs_n = 1'b0; repeat (6) @(negedge clk);
    chk("R2 co_oe open", 192'(co_oe), 192'(1));
    cs_n = 1'b1; repeat (6) @(negedge clk);
    chk("R2 co_oe closed", 192'(co_oe), 192'(0));

    // R10 aborted frame
    xfer(8'h0E, 8'hFF, 12, r);
    xfer(8'h0F, 8'h00, 16, r);
    chk("R10 abort no write", 192'(r), 192'(0));
    chk("R10 ctrl line0", 192'(ctrl_o[7:0]), 192'(0));
    xfer(8'h0E, 8'h80, 16, r);
    chk("R9 activate bit7", 192'(ctrl_o[7:0]), 192'(8'h80));

    // R8 interrupt with line1 enabled
    xfer(8'h1E, 8'h04, 16, r);
    ln_sig[1] = 1'b1; repeat (10) @(negedge clk);
    chk("R8 int on change", 192'(int_n), 192'(0));
    xfer(8'hFF, 8'h00, 16, r);
    chk("R5 status 01 line1", 192'(r), 192'(8'h04));
    chk("R8 int released", 192'(int_n), 192'(1));
    ln_sync[1] = 1'b1; repeat (10) @(negedge clk);
    chk("R8 int on sync", 192'(int_n), 192'(0));
    xfer(8'hFF, 8'h00, 16, r);
    chk("R5 status 11 line1", 192'(r), 192'(8'h0C));
    ln_sig[2] = 1'b1; repeat (10) @(negedge clk);
    chk("R8 masked line2", 192'(int_n), 192'(1));

    // R6 / R7 violation
    ln_bpv_tgl[1] = 1'b1; repeat (10) @(negedge clk);
    chk("R7 no int on violation", 192'(int_n), 192'(1));
    xfer(8'hFF, 8'h00, 16, r);
    chk("R6 status 10 line1", 192'(r), 192'(8'h18));
    xfer(8'hFF, 8'h00, 16, r);
    chk("R6 cleared to 11", 192'(r), 192'(8'h1C));
    chk("R7 int still high", 192'(int_n), 192'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule